// File: doc/BRIEF.md
# Key-Sequenced 64-bit Watchdog Timer

This peripheral guards a system against runaway software. A 64-bit up-counter runs against a 64-bit limit, and both are reached through a word-wide register port. Software loads the limit and counter while the block is idle. It picks a running mode and releases both counter halves. It then writes two 16-bit keys in a fixed order to arm the timer. From the first accepted key onward, the configuration is frozen. Only the key field of the watchdog control word still has any effect.

While armed, software must keep repeating the same two-key pair. The second key of each pair zeroes the counter. Three things trip the block: the counter reaching the limit, a key that is not the one expected next, or a pair given out of order. A trip raises a sticky flag and drives a reset-request pulse of fixed length. Only the module reset brings the block back to idle.

Top module: `seq_watchdog`

## Requirements
- R1: After reset, `wd_rst_req` is low and the watchdog control word reads 0. Both counter words read 0, and the block is idle.
- R2: The register address is a word index, so the byte offset is 4 times `addr`. The words are:
  - 0: identification, read-only, returns `ID_VALUE`.
  - 1: emulation control, read/write.
  - 4 and 5: counter low and high.
  - 6 and 7: limit low and high.
  - 8: timer control.
  - 9: global control.
  - 10: watchdog control.

  While idle, words 1 and 4 to 9 read back what was written.
- R3: The counter adds one per clock only when three conditions hold: timer control bits [7:6] are nonzero, global control bit 0 (low half released) is set, and bit 1 (high half released) is set. A half whose release bit is 0 reads 0. With mode 0, the counter holds its value.
- R4: Arming takes two steps. First, writing word 10 with bits [31:16] = 0xA5C6 and bit 14 set leaves idle for pre-active; this step is accepted only when global control bits [3:2] equal 2. Second, a later write with key 0xDA7E and bit 14 set enters active. The control word then reads bit 14 = 1.
- R5: From pre-active onward, writes to words 4 to 9 are ignored, and bit 14 of a control write has no effect. The enable stays set until the module reset.
- R6: In active, key 0xA5C6 enters service. In service, key 0xDA7E zeroes the counter and returns to active. So a counter read two clocks after that write returns 1.
- R7: In active or service, a control write whose key is not the expected next key trips the block. The flag (bit 15) and `wd_rst_req` go high on the clock edge that takes the write.
- R8: In active or service, when the counter equals the limit, the block trips on the next edge. With the counter at 0 and limit P, if mode is set on edge T0, `wd_rst_req` first reads high after edge T0+P+1.
- R9: `wd_rst_req` stays high for exactly `RST_CYCLES` clocks per trip. After a trip, the flag stays set and further key writes have no effect. The module reset clears it.
- R10: A read is registered: `rd_data` shows the word addressed while `rd_en` is high, from the next edge on. The control word reads 0 in bits [31:16], and unmapped words read 0.
- R11: In pre-active, a control write with a wrong key is ignored: there is no trip, and a following 0xDA7E still arms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous module reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word index of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| wd_rst_req | output | 1 | Reset request pulse on a trip |

## Verification
The key sequencer is driven with several patterns:
- the correct arm pair;
- a wrong key while pre-active;
- a zero key while active;
- a repeated first key while in service;
- the second key given without the first.

Together these separate the "ignore" path from the "trip" path in each state. The timeout is timed to the exact edge against a small limit, while steady servicing against a larger limit must never trip. This shows that the second key really clears the counter. Gated counting is tried with the mode at 0, with the halves held in reset, and while running. Writes made after arming show whether the lock covers the limit, the mode and the enable.

// File: rtl/seq_wdog_pkg.sv
package seq_wdog_pkg;

    localparam int REG_AW = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACTIVE,
        ST_SERVICE,
        ST_TRIPPED
    } wd_state_e;

    localparam logic [15:0] KEY_FIRST  = 16'hA5C6;
    localparam logic [15:0] KEY_SECOND = 16'hDA7E;

    localparam logic [REG_AW-1:0] IDX_ID     = 4'd0;
    localparam logic [REG_AW-1:0] IDX_EMU    = 4'd1;
    localparam logic [REG_AW-1:0] IDX_CNT_LO = 4'd4;
    localparam logic [REG_AW-1:0] IDX_CNT_HI = 4'd5;
    localparam logic [REG_AW-1:0] IDX_PRD_LO = 4'd6;
    localparam logic [REG_AW-1:0] IDX_PRD_HI = 4'd7;
    localparam logic [REG_AW-1:0] IDX_TCTL   = 4'd8;
    localparam logic [REG_AW-1:0] IDX_GCTL   = 4'd9;
    localparam logic [REG_AW-1:0] IDX_WCTL   = 4'd10;

    localparam int WD_EN_BIT   = 14;
    localparam int WD_FLAG_BIT = 15;
    localparam int KEY_LSB     = 16;

endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int DATA_W = 32,
    parameter int NUM_W  = 2,
    localparam int CNT_W = DATA_W * NUM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clear,
    input  logic [NUM_W-1:0]  release_w,
    input  logic [NUM_W-1:0]  wr_cnt,
    input  logic [NUM_W-1:0]  wr_prd,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  prd_o,
    output logic              hit
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] prd;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [NUM_W-1:0] word_eq;

    always_comb begin
        st_d = st_q;
        if (run) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        for (int w = 0; w < NUM_W; w++) begin
            if (wr_cnt[w]) begin
                st_d.cnt[w*DATA_W +: DATA_W] = wdata;
            end
            if (wr_prd[w]) begin
                st_d.prd[w*DATA_W +: DATA_W] = wdata;
            end
        end
        if (clear) begin
            st_d.cnt = '0;
        end
        for (int w = 0; w < NUM_W; w++) begin
            if (!release_w[w]) begin
                st_d.cnt[w*DATA_W +: DATA_W] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_W; g++) begin : g_cmp
        assign word_eq[g] = st_q.cnt[g*DATA_W +: DATA_W] == st_q.prd[g*DATA_W +: DATA_W];
    end

    assign hit   = &word_eq;
    assign cnt_o = st_q.cnt;
    assign prd_o = st_q.prd;

endmodule

// File: rtl/wdog_keyfsm.sv
module wdog_keyfsm
    import seq_wdog_pkg::*;
#(
    parameter int KEY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key,
    input  logic             en_bit,
    input  logic             arm_ok,
    input  logic             hit,
    output wd_state_e        state_o,
    output logic             clear_cnt,
    output logic             trip_evt
);

    typedef struct packed {
        wd_state_e state;
    } fsm_st_t;

    fsm_st_t st_d, st_q;
    logic    trip;

    always_comb begin
        st_d      = st_q;
        trip      = 1'b0;
        clear_cnt = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (key_wr && en_bit && arm_ok && key == KEY_FIRST) begin
                    st_d.state = ST_PRE;
                end
            end
            ST_PRE: begin
                if (key_wr && en_bit && key == KEY_SECOND) begin
                    st_d.state = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (hit) begin
                    trip = 1'b1;
                end else if (key_wr) begin
                    if (key == KEY_FIRST) begin
                        st_d.state = ST_SERVICE;
                    end else begin
                        trip = 1'b1;
                    end
                end
            end
            ST_SERVICE: begin
                if (hit) begin
                    trip = 1'b1;
                end else if (key_wr) begin
                    if (key == KEY_SECOND) begin
                        st_d.state = ST_ACTIVE;
                        clear_cnt  = 1'b1;
                    end else begin
                        trip = 1'b1;
                    end
                end
            end
            default: begin
                st_d.state = ST_TRIPPED;
            end
        endcase
        if (trip) begin
            st_d.state = ST_TRIPPED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    assign trip_evt = trip;
    assign state_o  = st_q.state;

endmodule

// File: rtl/wdog_rst_stretch.sv
module wdog_rst_stretch #(
    parameter int PULSE = 16,
    localparam int CW = $clog2(PULSE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic req
);

    typedef struct packed {
        logic [CW-1:0] left;
    } str_st_t;

    str_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.left = CW'(PULSE);
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.left != '0;

endmodule

// File: rtl/seq_watchdog.sv
module seq_watchdog
    import seq_wdog_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          KEY_W      = 16,
    parameter int          RST_CYCLES = 16,
    parameter logic [31:0] ID_VALUE   = 32'h5744_4701
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              wd_rst_req
);

    localparam int NUM_W = 2;
    localparam int CNT_W = NUM_W * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] tctl;
        logic [DATA_W-1:0] gctl;
        logic [DATA_W-1:0] emu;
        logic [DATA_W-1:0] rdata;
    } reg_st_t;

    reg_st_t          r_d, r_q;
    wd_state_e        fsm_state;
    logic             clear_cnt;
    logic             trip_evt;
    logic             hit;
    logic             locked;
    logic             trip_flag;
    logic             count_en;
    logic             key_wr;
    logic             arm_ok;
    logic [1:0]       run_mode;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] prd_val;
    logic [NUM_W-1:0] wr_cnt;
    logic [NUM_W-1:0] wr_prd;
    logic [NUM_W-1:0] release_w;

    assign locked    = fsm_state != ST_IDLE;
    assign trip_flag = fsm_state == ST_TRIPPED;
    assign run_mode  = r_q.tctl[7:6];
    assign arm_ok    = r_q.gctl[3:2] == 2'd2;
    assign key_wr    = wr_en && addr == IDX_WCTL;

    for (genvar g = 0; g < NUM_W; g++) begin : g_word
        assign release_w[g] = r_q.gctl[g];
        assign wr_cnt[g]    = wr_en && !locked && addr == (IDX_CNT_LO + REG_AW'(g));
        assign wr_prd[g]    = wr_en && !locked && addr == (IDX_PRD_LO + REG_AW'(g));
    end

    assign count_en = run_mode != 2'd0 && (&release_w) && !trip_flag;

    always_comb begin
        r_d = r_q;
        if (wr_en && !locked) begin
            if (addr == IDX_TCTL) begin
                r_d.tctl = wr_data;
            end
            if (addr == IDX_GCTL) begin
                r_d.gctl = wr_data;
            end
        end
        if (wr_en && addr == IDX_EMU) begin
            r_d.emu = wr_data;
        end
        if (rd_en) begin
            r_d.rdata = '0;
            case (addr)
                IDX_ID:     r_d.rdata = DATA_W'(ID_VALUE);
                IDX_EMU:    r_d.rdata = r_q.emu;
                IDX_CNT_LO: r_d.rdata = cnt_val[DATA_W-1:0];
                IDX_CNT_HI: r_d.rdata = cnt_val[CNT_W-1:DATA_W];
                IDX_PRD_LO: r_d.rdata = prd_val[DATA_W-1:0];
                IDX_PRD_HI: r_d.rdata = prd_val[CNT_W-1:DATA_W];
                IDX_TCTL:   r_d.rdata = r_q.tctl;
                IDX_GCTL:   r_d.rdata = r_q.gctl;
                IDX_WCTL: begin
                    r_d.rdata[WD_EN_BIT]   = locked;
                    r_d.rdata[WD_FLAG_BIT] = trip_flag;
                end
                default:    r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    wdog_counter #(
        .DATA_W (DATA_W),
        .NUM_W  (NUM_W)
    ) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (count_en),
        .clear     (clear_cnt),
        .release_w (release_w),
        .wr_cnt    (wr_cnt),
        .wr_prd    (wr_prd),
        .wdata     (wr_data),
        .cnt_o     (cnt_val),
        .prd_o     (prd_val),
        .hit       (hit)
    );

    wdog_keyfsm #(
        .KEY_W (KEY_W)
    ) i_keyfsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (key_wr),
        .key       (wr_data[KEY_LSB +: KEY_W]),
        .en_bit    (wr_data[WD_EN_BIT]),
        .arm_ok    (arm_ok),
        .hit       (hit),
        .state_o   (fsm_state),
        .clear_cnt (clear_cnt),
        .trip_evt  (trip_evt)
    );

    wdog_rst_stretch #(
        .PULSE (RST_CYCLES)
    ) i_stretch (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (trip_evt),
        .req   (wd_rst_req)
    );

    assign rd_data = r_q.rdata;

endmodule

// File: rtl/seq_watchdog_chk.sv
module seq_watchdog_chk
    import seq_wdog_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 64,
    parameter int RST_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [REG_AW-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input wd_state_e         state,
    input logic              locked,
    input logic              flag,
    input logic              rst_req,
    input logic [1:0]        mode,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  prd
);

    localparam int HW = $clog2(RST_CYCLES + 1) + 1;

    logic [HW-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (rst_req) begin
            hi_q <= hi_q + 1'b1;
        end else begin
            hi_q <= '0;
        end
    end

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> flag);

    p_rst_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> hi_q < HW'(RST_CYCLES));

    p_rst_on_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> rst_req);

    p_enable_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    p_lock_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> $stable(prd));

    p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && mode == 2'd0) |=> $stable(cnt));

    p_key_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == IDX_WCTL && state == ST_ACTIVE
         && wr_data[KEY_LSB +: 16] != KEY_FIRST) |=> flag);

    p_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ACTIVE || state == ST_SERVICE) && cnt == prd) |=> flag);

endmodule

bind seq_watchdog seq_watchdog_chk #(
    .DATA_W     (DATA_W),
    .CNT_W      (CNT_W),
    .RST_CYCLES (RST_CYCLES)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .state   (fsm_state),
    .locked  (locked),
    .flag    (trip_flag),
    .rst_req (wd_rst_req),
    .mode    (run_mode),
    .cnt     (cnt_val),
    .prd     (prd_val)
);

// File: tb/test_seq_watchdog.sv
`timescale 1ns/1ps
module test_seq_watchdog;

    localparam int RSTC = 16;
    localparam logic [31:0] IDV = 32'h5744_4701;
    localparam logic [31:0] ARM0 = 32'hA5C6_4000;
    localparam logic [31:0] ARM1 = 32'hDA7E_4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        wd_rst_req;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    seq_watchdog #(.RST_CYCLES(RSTC), .ID_VALUE(IDV)) i_seq_watchdog (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .wd_rst_req(wd_rst_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic setup(input logic [31:0] limit);
        do_reset();
        wr(4'd9, 32'hB);
        wr(4'd6, limit);
        wr(4'd7, 32'h0);
        wr(4'd4, 32'h0);
        wr(4'd5, 32'h0);
        wr(4'd8, 32'h80);
    endtask

    task automatic arm();
        wr(4'd10, ARM0);
        wr(4'd10, ARM1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        chk("R1 rst_req", {31'd0, wd_rst_req}, 32'd0);
        rd(4'd10, v); chk("R1 wdctl", v, 32'd0);
        rd(4'd4, v);  chk("R1 cnt lo", v, 32'd0);
        rd(4'd5, v);  chk("R1 cnt hi", v, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        do_reset();
        wr(4'd9, 32'hB);
        wr(4'd6, 32'h1234_5678);
        wr(4'd7, 32'h0000_CAFE);
        wr(4'd5, 32'h0000_ABCD);
        wr(4'd1, 32'h5);
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd6, v); chk("R2 limit lo", v, 32'h1234_5678);
        rd(4'd7, v); chk("R2 limit hi", v, 32'h0000_CAFE);
        rd(4'd5, v); chk("R2 cnt hi", v, 32'h0000_ABCD);
        rd(4'd1, v); chk("R2 emu", v, 32'h5);
        rd(4'd9, v); chk("R2 gctl", v, 32'hB);
        rd(4'd0, v); chk("R2 id", v, IDV);
        rd(4'd2, v); chk("R10 unmapped", v, 32'd0);
    endtask

    task automatic t_count_gate();
        logic [31:0] a, b;
        do_reset();
        wr(4'd9, 32'hB);
        wr(4'd4, 32'd7);
        repeat (10) @(negedge clk);
        rd(4'd4, a); chk("R3 mode0 hold", a, 32'd7);
        wr(4'd8, 32'h80);
        rd(4'd4, a); rd(4'd4, b);
        chk("R3 run step", b - a, 32'd2);
        wr(4'd9, 32'h8);
        rd(4'd4, a); chk("R3 lo held in reset", a, 32'd0);
        repeat (5) @(negedge clk);
        rd(4'd4, a); chk("R3 lo still zero", a, 32'd0);
    endtask

    task automatic t_arm();
        logic [31:0] v;
        do_reset();
        wr(4'd9, 32'h3);
        arm();
        rd(4'd10, v); chk("R4 arm refused", v, 32'd0);
        wr(4'd9, 32'hB);
        wr(4'd6, 32'd1000);
        arm();
        rd(4'd10, v); chk("R4 armed wdctl", v, 32'h4000);
        chk("R4 no rst", {31'd0, wd_rst_req}, 32'd0);
    endtask

    task automatic t_lock();
        logic [31:0] a, b;
        setup(32'd1000);
        arm();
        wr(4'd6, 32'hFFFF_FFFF);
        rd(4'd6, a); chk("R5 limit locked", a, 32'd1000);
        wr(4'd8, 32'h0);
        rd(4'd4, a); rd(4'd4, b);
        chk("R5 mode locked", b - a, 32'd2);
        wr(4'd10, 32'hA5C6_0000);
        wr(4'd10, 32'hDA7E_0000);
        rd(4'd10, a); chk("R5 enable kept", a, 32'h4000);
        chk("R5 no rst", {31'd0, wd_rst_req}, 32'd0);
    endtask

    task automatic t_service();
        logic [31:0] v;
        setup(32'd200);
        arm();
        for (int i = 0; i < 5; i++) begin
            repeat (100) @(negedge clk);
            wr(4'd10, ARM0);
            wr(4'd10, ARM1);
        end
        rd(4'd4, v); chk("R6 cleared count", v, 32'd1);
        chk("R6 no rst", {31'd0, wd_rst_req}, 32'd0);
        rd(4'd10, v); chk("R6 no flag", v, 32'h4000);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        int t0;
        int seen;
        int len;
        setup(32'd60);
        t0 = cyc;
        arm();
        seen = -1;
        for (int i = 0; i < 200 && seen < 0; i++) begin
            if (wd_rst_req) seen = cyc;
            else @(negedge clk);
        end
        chk("R8 timeout edge", seen, t0 + 61);
        len = 0;
        while (wd_rst_req && len < 100) begin
            len++;
            @(negedge clk);
        end
        chk("R9 pulse length", len, RSTC);
        rd(4'd10, v); chk("R9 flag set", v, 32'hC000);
        arm();
        rd(4'd10, v); chk("R9 flag sticky", v, 32'hC000);
        chk("R9 no repulse", {31'd0, wd_rst_req}, 32'd0);
        do_reset();
        rd(4'd10, v); chk("R9 reset clears", v, 32'd0);
    endtask

    task automatic t_bad_key();
        logic [31:0] v;
        setup(32'd1000);
        arm();
        wr(4'd10, 32'h0000_4000);
        chk("R7 zero key rst", {31'd0, wd_rst_req}, 32'd1);
        rd(4'd10, v); chk("R7 zero key flag", v, 32'hC000);
        setup(32'd1000);
        arm();
        wr(4'd10, ARM0);
        wr(4'd10, ARM0);
        chk("R7 service repeat rst", {31'd0, wd_rst_req}, 32'd1);
        setup(32'd1000);
        arm();
        wr(4'd10, ARM1);
        chk("R7 second key alone", {31'd0, wd_rst_req}, 32'd1);
    endtask

    task automatic t_pre_wrong();
        logic [31:0] v;
        setup(32'd1000);
        wr(4'd10, ARM0);
        wr(4'd10, 32'h1111_4000);
        chk("R11 no rst", {31'd0, wd_rst_req}, 32'd0);
        rd(4'd10, v); chk("R11 pre kept", v, 32'h4000);
        wr(4'd10, ARM1);
        wr(4'd10, ARM0);
        wr(4'd10, ARM1);
        chk("R11 arms after", {31'd0, wd_rst_req}, 32'd0);
        rd(4'd10, v); chk("R11 no flag", v, 32'h4000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_regs();
        t_count_gate();
        t_arm();
        t_lock();
        t_service();
        t_timeout();
        t_bad_key();
        t_pre_wrong();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule